// File: doc/BRIEF.md
# Field DMA Read Address Generator

This block produces the memory read requests needed to pull one field of a video source frame out of system memory. Software sets two field start addresses (one for odd fields, one for even fields), a line pitch, a line count per field and a byte count per line. A start pulse captures these settings and begins a field. The block then walks each line in 4-byte (Dword) steps and jumps to the next line by adding the pitch to the start of the current line. Because the pitch can be larger than the line length, a window can be cut out of a wider frame buffer.

Each request carries one Dword address and a byte-enable mask. It is offered to a downstream FIFO over a valid/ready handshake. The FIFO's almost-full flag holds back new requests without losing any address. The field parity flips at every accepted start, so odd and even fields fetch from their own start addresses in turn. A single-cycle completion pulse follows the last accepted request of the field.

Top module: `vfield_fetch_agen`

## Requirements
- R1: While `rst` is high, and after it is released with no start, `req_valid`, `field_done`, `busy`, `field_odd` and `pitch_err` are all 0.
- R2: A `start` pulse seen while idle captures the configuration, raises `busy` and inverts `field_odd`. The first field after reset is odd (`field_odd`=1) and fetches from `base_odd`. Later fields alternate between `base_even` and `base_odd`.
- R3: The two low bits of the selected start address and of `line_pitch` are treated as zero. `pitch_err` shows whether `line_pitch[1:0]` was nonzero at the accepted start, and keeps that value until the next accepted start.
- R4: Line k of a field (k counted from 0) starts at base + k*pitch. Within a line, request addresses rise by 4 for each Dword. Every request address has bits [1:0] = 0.
- R5: Each line issues ceil(`line_bytes`/4) requests. All but the last carry `req_be`=4'hF. The last carries 4'hF when `line_bytes` mod 4 is 0, and otherwise 4'h1, 4'h3 or 4'h7 for remainders 1, 2 or 3 (bit i enables byte address+i).
- R6: A request is transferred in a cycle where `req_valid` and `req_ready` are both 1. While `req_valid` is 1 and `req_ready` is 0, `req_valid`, `req_addr` and `req_be` hold their values.
- R7: `req_valid` does not rise in a cycle after one in which `fifo_afull` was 1. Once `fifo_afull` clears, the request stream resumes at the next address, with none skipped.
- R8: `field_done` is 1 for exactly one cycle: the cycle after the last request of the field is transferred. `busy` is 0 in that same cycle. A field with zero lines or zero bytes issues no request and still produces one `field_done` pulse.
- R9: A `start` pulse while `busy` is 1 is ignored. `field_odd` does not change, and the running field's addresses and request count are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a new field (taken only while idle) |
| base_odd | input | ADDR_W | Start address for odd fields |
| base_even | input | ADDR_W | Start address for even fields |
| line_pitch | input | PITCH_W | Byte distance between consecutive line starts |
| field_lines | input | LINE_W | Lines per field |
| line_bytes | input | BYTE_W | Bytes fetched per line |
| fifo_afull | input | 1 | Downstream FIFO almost full; blocks new requests |
| req_ready | input | 1 | Downstream accepts the offered request |
| req_valid | output | 1 | Request offered |
| req_addr | output | ADDR_W | Dword-aligned read address |
| req_be | output | 4 | Byte enables for the Dword |
| field_done | output | 1 | One-cycle pulse after the last request of a field |
| busy | output | 1 | A field is in progress |
| field_odd | output | 1 | Parity of the current or most recent field (1 = odd) |
| pitch_err | output | 1 | Captured pitch had nonzero low bits |

## Verification
The assertions check on every cycle the rules that do not depend on how the field is set up:
- requests stay stable while stalled;
- no new request is raised after an almost-full cycle;
- every address is Dword aligned and every byte mask is a legal contiguous form;
- the done pulse is a single cycle and occurs only while idle;
- parity inverts exactly at a field start and holds while busy.

The bench scenarios are needed for the rest. They show:
- the exact order of addresses across lines with different pitches;
- the per-line Dword count and the tail mask for each byte remainder;
- the done pulse landing one cycle after the final transfer;
- empty fields, ignored restarts, and resumption after an almost-full stall with no address lost.

// File: rtl/vff_pkg.sv
package vff_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PREP = 2'd1,
    ST_RUN  = 2'd2
  } vff_state_e;

  localparam logic [3:0] BE_ALL = 4'hF;

  // Byte mask for the final Dword of a line, from the byte remainder.
  function automatic logic [3:0] tail_mask(input logic [1:0] rem);
    logic [3:0] m;
    case (rem)
      2'd1:    m = 4'h1;
      2'd2:    m = 4'h3;
      2'd3:    m = 4'h7;
      default: m = BE_ALL;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/vff_cfg_latch.sv
module vff_cfg_latch #(
  parameter int ADDR_W  = 32,
  parameter int PITCH_W = 16,
  parameter int LINE_W  = 12,
  parameter int BYTE_W  = 14,
  localparam int DPL_W  = BYTE_W - 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               take,
  input  logic [ADDR_W-1:0]  base_odd_i,
  input  logic [ADDR_W-1:0]  base_even_i,
  input  logic [PITCH_W-1:0] pitch_i,
  input  logic [LINE_W-1:0]  lines_i,
  input  logic [BYTE_W-1:0]  bytes_i,
  output logic [ADDR_W-1:0]  base_o,
  output logic [PITCH_W-1:0] pitch_o,
  output logic [LINE_W-1:0]  lines_o,
  output logic [DPL_W-1:0]   dpl_o,
  output logic [3:0]         tail_be_o,
  output logic               odd_o,
  output logic               pitch_err_o
);
  import vff_pkg::*;

  logic [ADDR_W-1:0] base_pick;
  logic [DPL_W-1:0]  dw_per_line;
  logic              empty_field;

  // The parity flips on take, so the new field uses the opposite of odd_o.
  assign base_pick   = (!odd_o) ? base_odd_i : base_even_i;
  assign dw_per_line = DPL_W'(bytes_i[BYTE_W-1:2]) + DPL_W'(|bytes_i[1:0]);
  assign empty_field = (bytes_i == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      base_o      <= '0;
      pitch_o     <= '0;
      lines_o     <= '0;
      dpl_o       <= '0;
      tail_be_o   <= BE_ALL;
      odd_o       <= 1'b0;
      pitch_err_o <= 1'b0;
    end else if (take) begin
      odd_o       <= ~odd_o;
      base_o      <= base_pick & ~ADDR_W'(3);
      pitch_o     <= pitch_i & ~PITCH_W'(3);
      lines_o     <= empty_field ? '0 : lines_i;
      dpl_o       <= dw_per_line;
      tail_be_o   <= tail_mask(bytes_i[1:0]);
      pitch_err_o <= |pitch_i[1:0];
    end
  end

endmodule

// File: rtl/vff_walker.sv
module vff_walker #(
  parameter int ADDR_W  = 32,
  parameter int PITCH_W = 16,
  parameter int LINE_W  = 12,
  parameter int DPL_W   = 13
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic               step,
  input  logic [ADDR_W-1:0]  base_i,
  input  logic [PITCH_W-1:0] pitch_i,
  input  logic [LINE_W-1:0]  lines_i,
  input  logic [DPL_W-1:0]   dpl_i,
  input  logic [3:0]         tail_be_i,
  output logic [ADDR_W-1:0]  addr_o,
  output logic [3:0]         be_o,
  output logic               more_o
);
  import vff_pkg::*;

  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] line_q;
  logic [DPL_W-1:0]  dw_left_q;
  logic [LINE_W-1:0] lines_left_q;
  logic              more_q;

  logic [ADDR_W-1:0] pitch_ext;
  logic [ADDR_W-1:0] next_line;
  logic              end_of_line;
  logic              final_line;

  assign pitch_ext   = {{(ADDR_W-PITCH_W){1'b0}}, pitch_i};
  assign next_line   = line_q + pitch_ext;
  assign end_of_line = (dw_left_q == DPL_W'(1));
  assign final_line  = (lines_left_q == LINE_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q       <= '0;
      line_q       <= '0;
      dw_left_q    <= '0;
      lines_left_q <= '0;
      more_q       <= 1'b0;
    end else if (load) begin
      addr_q       <= base_i;
      line_q       <= base_i;
      dw_left_q    <= dpl_i;
      lines_left_q <= lines_i;
      more_q       <= (dpl_i != '0) && (lines_i != '0);
    end else if (step && more_q) begin
      if (end_of_line) begin
        if (final_line) begin
          more_q <= 1'b0;
        end else begin
          line_q       <= next_line;
          addr_q       <= next_line;
          dw_left_q    <= dpl_i;
          lines_left_q <= lines_left_q - LINE_W'(1);
        end
      end else begin
        addr_q    <= addr_q + ADDR_W'(4);
        dw_left_q <= dw_left_q - DPL_W'(1);
      end
    end
  end

  assign addr_o = addr_q;
  assign be_o   = end_of_line ? tail_be_i : BE_ALL;
  assign more_o = more_q;

endmodule

// File: rtl/vff_req_out.sv
module vff_req_out #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue,
  input  logic              drop,
  input  logic              done,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [3:0]        be_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [3:0]        be_o,
  output logic              done_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      addr_o  <= '0;
      be_o    <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= done;
      if (issue) begin
        valid_o <= 1'b1;
        addr_o  <= addr_i;
        be_o    <= be_i;
      end else if (drop) begin
        valid_o <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/vfield_fetch_agen.sv
module vfield_fetch_agen #(
  parameter int ADDR_W  = 32,
  parameter int PITCH_W = 16,
  parameter int LINE_W  = 12,
  parameter int BYTE_W  = 14,
  localparam int DPL_W  = BYTE_W - 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [ADDR_W-1:0]  base_odd,
  input  logic [ADDR_W-1:0]  base_even,
  input  logic [PITCH_W-1:0] line_pitch,
  input  logic [LINE_W-1:0]  field_lines,
  input  logic [BYTE_W-1:0]  line_bytes,
  input  logic               fifo_afull,
  input  logic               req_ready,
  output logic               req_valid,
  output logic [ADDR_W-1:0]  req_addr,
  output logic [3:0]         req_be,
  output logic               field_done,
  output logic               busy,
  output logic               field_odd,
  output logic               pitch_err
);
  import vff_pkg::*;

  vff_state_e state_q;

  logic               start_take;
  logic               slot_free;
  logic               in_run;
  logic               issue;
  logic               finish;
  logic               drop;

  logic [ADDR_W-1:0]  c_base;
  logic [PITCH_W-1:0] c_pitch;
  logic [LINE_W-1:0]  c_lines;
  logic [DPL_W-1:0]   c_dpl;
  logic [3:0]         c_tail;

  logic [ADDR_W-1:0]  w_addr;
  logic [3:0]         w_be;
  logic               w_more;

  assign start_take = start && (state_q == ST_IDLE);
  assign in_run     = (state_q == ST_RUN);
  assign slot_free  = !req_valid || req_ready;
  assign issue      = in_run && slot_free && w_more && !fifo_afull;
  assign finish     = in_run && slot_free && !w_more;
  assign drop       = in_run && slot_free;
  assign busy       = (state_q != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
    end else begin
      case (state_q)
        ST_IDLE: if (start_take) state_q <= ST_PREP;
        ST_PREP: state_q <= ST_RUN;
        ST_RUN:  if (finish) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  vff_cfg_latch #(
    .ADDR_W (ADDR_W),
    .PITCH_W(PITCH_W),
    .LINE_W (LINE_W),
    .BYTE_W (BYTE_W)
  ) u_cfg (
    .clk        (clk),
    .rst        (rst),
    .take       (start_take),
    .base_odd_i (base_odd),
    .base_even_i(base_even),
    .pitch_i    (line_pitch),
    .lines_i    (field_lines),
    .bytes_i    (line_bytes),
    .base_o     (c_base),
    .pitch_o    (c_pitch),
    .lines_o    (c_lines),
    .dpl_o      (c_dpl),
    .tail_be_o  (c_tail),
    .odd_o      (field_odd),
    .pitch_err_o(pitch_err)
  );

  vff_walker #(
    .ADDR_W (ADDR_W),
    .PITCH_W(PITCH_W),
    .LINE_W (LINE_W),
    .DPL_W  (DPL_W)
  ) u_walk (
    .clk      (clk),
    .rst      (rst),
    .load     (state_q == ST_PREP),
    .step     (issue),
    .base_i   (c_base),
    .pitch_i  (c_pitch),
    .lines_i  (c_lines),
    .dpl_i    (c_dpl),
    .tail_be_i(c_tail),
    .addr_o   (w_addr),
    .be_o     (w_be),
    .more_o   (w_more)
  );

  vff_req_out #(
    .ADDR_W(ADDR_W)
  ) u_out (
    .clk    (clk),
    .rst    (rst),
    .issue  (issue),
    .drop   (drop),
    .done   (finish),
    .addr_i (w_addr),
    .be_i   (w_be),
    .valid_o(req_valid),
    .addr_o (req_addr),
    .be_o   (req_be),
    .done_o (field_done)
  );

endmodule

// File: rtl/vfield_fetch_agen_chk.sv
module vfield_fetch_agen_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              fifo_afull,
  input logic              req_ready,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_addr,
  input logic [3:0]        req_be,
  input logic              field_done,
  input logic              busy,
  input logic              field_odd
);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !req_valid);

  a_r2_parity_flip: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (field_odd != $past(field_odd)));

  a_r4_dword_aligned: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> (req_addr[1:0] == 2'b00));

  a_r5_be_form: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> (req_be inside {4'h1, 4'h3, 4'h7, 4'hF}));

  a_r6_hold_stable: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_be)));

  a_r7_no_raise_afull: assert property (@(posedge clk) disable iff (rst)
    (!req_valid && fifo_afull) |=> !req_valid);

  a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
    field_done |=> !field_done);

  a_r8_done_idle: assert property (@(posedge clk) disable iff (rst)
    field_done |-> (!busy && !req_valid));

  a_r9_parity_hold: assert property (@(posedge clk) disable iff (rst)
    ($past(busy) && busy) |-> $stable(field_odd));

endmodule

bind vfield_fetch_agen vfield_fetch_agen_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/vfield_fetch_agen_bench.sv
`timescale 1ns/1ps
module vfield_fetch_agen_bench;

  typedef struct packed {
    logic [31:0] bo;
    logic [31:0] bev;
    logic [15:0] pitch;
    logic [11:0] lines;
    logic [13:0] nbytes;
    logic [1:0]  mode;   // bit0: random ready, bit1: random almost-full
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VECS [NVEC] = '{
    '{32'h0000_1000, 32'h0000_8000, 16'h0040, 12'd3, 14'd16, 2'd0},
    '{32'h0000_2000, 32'h0000_9004, 16'h0100, 12'd4, 14'd13, 2'd1},
    '{32'h0000_3003, 32'h0000_B000, 16'h0083, 12'd2, 14'd6,  2'd2},
    '{32'h0000_3000, 32'h0000_A000, 16'h0020, 12'd5, 14'd3,  2'd3},
    '{32'h0000_5000, 32'h0000_D000, 16'h0040, 12'd0, 14'd8,  2'd0},
    '{32'h0000_5000, 32'h0000_D000, 16'h0040, 12'd2, 14'd0,  2'd1},
    '{32'h0000_6000, 32'h0000_E000, 16'h0010, 12'd6, 14'd20, 2'd3}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] base_odd = '0;
  logic [31:0] base_even = '0;
  logic [15:0] line_pitch = '0;
  logic [11:0] field_lines = '0;
  logic [13:0] line_bytes = '0;
  logic        fifo_afull = 1'b0;
  logic        req_ready = 1'b1;
  logic        req_valid;
  logic [31:0] req_addr;
  logic [3:0]  req_be;
  logic        field_done;
  logic        busy;
  logic        field_odd;
  logic        pitch_err;

  int          checks = 0;
  int          fails = 0;
  int          cyc = 0;
  bit          exp_odd = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  vfield_fetch_agen u_vfield_fetch_agen (
    .clk(clk), .rst(rst), .start(start),
    .base_odd(base_odd), .base_even(base_even), .line_pitch(line_pitch),
    .field_lines(field_lines), .line_bytes(line_bytes),
    .fifo_afull(fifo_afull), .req_ready(req_ready),
    .req_valid(req_valid), .req_addr(req_addr), .req_be(req_be),
    .field_done(field_done), .busy(busy), .field_odd(field_odd),
    .pitch_err(pitch_err)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_tail(input logic [13:0] b);
    case (b[1:0])
      2'd1:    return 4'h1;
      2'd2:    return 4'h3;
      2'd3:    return 4'h7;
      default: return 4'hF;
    endcase
  endfunction

  task automatic run_field(input vec_t v, input bit busy_start);
    logic [31:0] base;
    logic [31:0] pm;
    logic [31:0] ea;
    logic [3:0]  eb;
    int dpl, total, idx, last_fire, done_cyc, it;
    bit done_seen;
    exp_odd   = !exp_odd;
    base      = (exp_odd ? v.bo : v.bev) & 32'hFFFF_FFFC;
    pm        = {16'h0, v.pitch & 16'hFFFC};
    dpl       = (int'(v.nbytes) + 3) / 4;
    total     = (v.nbytes == 0) ? 0 : dpl * int'(v.lines);
    @(negedge clk);
    base_odd = v.bo; base_even = v.bev; line_pitch = v.pitch;
    field_lines = v.lines; line_bytes = v.nbytes;
    req_ready = 1'b1; fifo_afull = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(field_odd == exp_odd, "R2", "field parity after start", 32'(field_odd), 32'(exp_odd));
    chk(busy == 1'b1, "R2", "busy after start", 32'(busy), 32'd1);
    chk(pitch_err == (v.pitch[1:0] != 2'b00), "R3", "pitch_err flag",
        32'(pitch_err), 32'(v.pitch[1:0] != 2'b00));
    idx = 0; last_fire = -10; done_cyc = -1; done_seen = 1'b0; it = 0;
    while (!done_seen && it < 4000) begin
      @(negedge clk);
      it++;
      if (field_done) begin
        done_seen = 1'b1;
        done_cyc  = cyc;
      end
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      req_ready  = v.mode[0] ? (lfsr[0] | lfsr[3]) : 1'b1;
      fifo_afull = v.mode[1] ? (lfsr[5] & lfsr[7]) : 1'b0;
      if (busy_start && it == 4) begin
        // R9: restart attempt with altered settings while busy
        start = 1'b1; field_lines = 12'd7; base_odd = 32'h0000_7700;
      end else begin
        start = 1'b0;
      end
      if (req_valid && req_ready) begin
        if (idx < total) begin
          ea = base + 32'(idx / dpl) * pm + 32'((idx % dpl) * 4);
          eb = ((idx % dpl) == dpl - 1) ? exp_tail(v.nbytes) : 4'hF;
          chk(req_addr == ea, (v.pitch[1:0] != 2'b00) ? "R3" : "R4",
              "request address", req_addr, ea);
          chk(req_be == eb, "R5", "byte enables", 32'(req_be), 32'(eb));
        end else begin
          chk(1'b0, "R5", "extra request address", req_addr, 32'hFFFF_FFFF);
        end
        idx++;
        last_fire = cyc;
      end
    end
    start = 1'b0; req_ready = 1'b1; fifo_afull = 1'b0;
    chk(done_seen, "R8", "field_done seen", 32'(done_seen), 32'd1);
    chk(idx == total, "R5", "requests per field", 32'(idx), 32'(total));
    if (total > 0)
      chk(done_cyc == last_fire + 1, "R8", "done cycle after last transfer",
          32'(done_cyc), 32'(last_fire + 1));
    chk(busy == 1'b0, "R8", "busy low with done", 32'(busy), 32'd0);
    chk(field_odd == exp_odd, busy_start ? "R9" : "R2", "parity kept to field end",
        32'(field_odd), 32'(exp_odd));
    @(negedge clk);
    chk(field_done == 1'b0, "R8", "done is single cycle", 32'(field_done), 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=<20000 cycles", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] b;
    // R1: reset values
    repeat (3) @(negedge clk);
    chk(!req_valid && !field_done && !busy && !field_odd && !pitch_err, "R1",
        "outputs during reset",
        {27'd0, req_valid, field_done, busy, field_odd, pitch_err}, 32'd0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk(!req_valid && !field_done && !busy && !field_odd && !pitch_err, "R1",
        "outputs idle after reset",
        {27'd0, req_valid, field_done, busy, field_odd, pitch_err}, 32'd0);

    for (int i = 0; i < NVEC; i++) begin
      run_field(VECS[i], i == NVEC - 1);
    end

    // Directed: stall hold (R6) and almost-full pause without skip (R7)
    exp_odd = !exp_odd;
    b = exp_odd ? 32'h0000_4000 : 32'h0000_C000;
    @(negedge clk);
    base_odd = 32'h0000_4000; base_even = 32'h0000_C000; line_pitch = 16'h0040;
    field_lines = 12'd1; line_bytes = 14'd12;
    req_ready = 1'b0; fifo_afull = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 10 && !req_valid; k++) @(negedge clk);
    chk(req_valid, "R6", "first request offered", 32'(req_valid), 32'd1);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(req_valid && req_addr == b && req_be == 4'hF, "R6", "request held while not ready",
          req_addr, b);
    end
    req_ready = 1'b1; fifo_afull = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(!req_valid, "R7", "no request while almost full", 32'(req_valid), 32'd0);
    end
    fifo_afull = 1'b0;
    @(negedge clk);
    chk(req_valid && req_addr == b + 32'd4, "R7", "resume at next address",
        req_addr, b + 32'd4);
    @(negedge clk);
    chk(req_valid && req_addr == b + 32'd8 && req_be == 4'hF, "R5",
        "last Dword of 12-byte line", {req_addr[27:0], req_be}, {b[27:0] + 28'd8, 4'hF});
    @(negedge clk);
    chk(field_done && !busy, "R8", "done after directed field",
        {30'd0, field_done, busy}, 32'd2);
    chk(field_odd == exp_odd, "R2", "parity of directed field", 32'(field_odd), 32'(exp_odd));

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule